// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Sequencer

This block keeps the contents of an asynchronous DRAM alive. After reset it holds off for a programmable power-up pause. It then issues a fixed number of dummy refresh cycles, after which it reports that the memory is ready. From then on an interval timer marks one refresh as owed each period. The average period is chosen so that all rows are covered inside the retention window, for example 4096 rows every 64 ms, or about one refresh per 15.6 µs. Refreshes that have not yet been issued are kept in a small debt counter.

The block shares the row strobe, column strobe and write-enable lines with an access controller through a request/grant pair. It raises `ref_req` whenever it has work to do. It starts a refresh only when it sees `ref_gnt` high, and it keeps `ref_req` high until that refresh, including its precharge, has finished. A build-time parameter selects one of two refresh styles. Column-before-row refresh lets the DRAM use its internal row counter, with the column strobe dropping first. Row-only refresh presents a row from the block's own counter, which wraps to zero after the last row, and keeps the column strobe high. If the grant is withheld long enough for the debt to overflow, a sticky starvation error is raised.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `ras_n`, `cas_n` and `we_n` are 1, and `ref_req`, `init_done` and `starve_err` are 0.
- R2: `ref_req` stays 0 for the first INIT_PAUSE_CYC-1 rising edges after reset release and is 1 after edge INIT_PAUSE_CYC.
- R3: With the grant held, exactly INIT_REFRESHES refresh cycles follow the pause, starting every LEAD_CYC+RAS_CYC+PRE_CYC+1 cycles. `init_done` rises one cycle after the last of them ends and then stays 1.
- R4: In column-before-row mode `cas_n` is 0 for exactly LEAD_CYC cycles before `ras_n` falls. Both are then 0 for exactly RAS_CYC cycles and rise on the same edge.
- R5: `we_n` is 1 on every cycle in which `ras_n` falls, so a refresh never enters the DRAM's test mode.
- R6: In row-only mode `cas_n` stays 1 while `ras_n` is 0, and `row_addr` is stable while `ras_n` is 0. Successive refreshes present rows 0, 1, 2, and so on, wrapping from 2^ROW_W-1 to 0.
- R7: After `ras_n` rises it stays 1 for at least PRE_CYC cycles before the next strobe falls.
- R8: A refresh starts only on an edge where `ref_req` and `ref_gnt` are both 1. While `ref_req` is 0 the strobes are 1. While the grant is withheld, `ref_req` stays 1 and no strobe falls.
- R9: After `init_done`, one refresh becomes owed every INTERVAL_CYC cycles. With the grant held, the first `cas_n` fall comes INTERVAL_CYC+1 cycles after `init_done` rises, and later falls are INTERVAL_CYC cycles apart.
- R10: Up to MAX_OWED refreshes accumulate while the grant is withheld. An interval that expires with MAX_OWED already owed sets `starve_err`. When the grant returns, exactly MAX_OWED refreshes run back to back, and then `ref_req` falls.
- R11: `starve_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Strobe ownership granted by the access controller |
| ref_req | output | 1 | Refresh work pending or in progress |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high during refresh |
| row_addr | output | ROW_W | Row presented in row-only mode |
| addr_drive | output | 1 | Block is driving `row_addr` onto the address bus |
| init_done | output | 1 | Power-up sequence complete |
| starve_err | output | 1 | Sticky refresh-debt overflow error |

## Verification
Every output is a flop fed from the next-state logic, so a strobe changes on the same edge that starts a phase. A start happens one edge after both `ref_req` and `ref_gnt` are seen high. An owed refresh appears on the edge after the interval counter's last count, so the first timed refresh follows `init_done` by INTERVAL_CYC+1 edges. A starvation error appears on the edge of the fourth interval expiry after the grant is dropped, which is 4·INTERVAL_CYC-1 edges after the refresh that was then starting. The bench counts edges from reset or from a recorded event, samples half a period after the edge, and compares against these counts worked out from the parameters. It also sweeps the row-only instance through more than 2^ROW_W refreshes to check every row value and the wrap.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LEAD = 2'd1,
        PH_ACT  = 2'd2,
        PH_PRE  = 2'd3
    } ref_phase_e;

    // bits needed to hold the value n
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dram_ref_interval.sv
module dram_ref_interval #(
    parameter int unsigned INTERVAL_CYC = 1950
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = dram_ref_pkg::cnt_width(INTERVAL_CYC);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        tick  = en && (tmr_q.cnt == LAST);
        if (!en || tick) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/dram_ref_debt.sv
module dram_ref_debt #(
    parameter int unsigned MAX_OWED = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic take,
    output logic pending,
    output logic starve
);
    localparam int unsigned OW = dram_ref_pkg::cnt_width(MAX_OWED);
    localparam logic [OW-1:0] FULL = OW'(MAX_OWED);

    typedef struct packed {
        logic [OW-1:0] owed;
        logic          starve;
    } debt_t;

    debt_t debt_d, debt_q;

    always_comb begin
        debt_d = debt_q;
        unique case ({tick, take})
            2'b10: begin
                if (debt_q.owed == FULL) begin
                    debt_d.starve = 1'b1;
                end else begin
                    debt_d.owed = debt_q.owed + OW'(1);
                end
            end
            2'b01: begin
                if (debt_q.owed != '0) begin
                    debt_d.owed = debt_q.owed - OW'(1);
                end
            end
            default: ;
        endcase
    end

    assign pending = (debt_q.owed != '0);
    assign starve  = debt_q.starve;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            debt_q <= '0;
        end else begin
            debt_q <= debt_d;
        end
    end
endmodule

// File: rtl/dram_ref_init.sv
module dram_ref_init #(
    parameter int unsigned PAUSE_CYC  = 25000,
    parameter int unsigned INIT_COUNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic seq_idle,
    output logic pending,
    output logic done
);
    localparam int unsigned PW = dram_ref_pkg::cnt_width(PAUSE_CYC);
    localparam int unsigned NW = dram_ref_pkg::cnt_width(INIT_COUNT);
    localparam logic [PW-1:0] PAUSE_END = PW'(PAUSE_CYC);
    localparam logic [NW-1:0] COUNT_V   = NW'(INIT_COUNT);

    typedef struct packed {
        logic [PW-1:0] pause;
        logic [NW-1:0] left;
        logic          done;
    } init_t;

    init_t ini_d, ini_q;

    always_comb begin
        ini_d = ini_q;
        if (ini_q.pause != PAUSE_END) begin
            ini_d.pause = ini_q.pause + PW'(1);
        end
        if (take && ini_q.left != '0) begin
            ini_d.left = ini_q.left - NW'(1);
        end
        if (!ini_q.done && ini_q.left == '0 && seq_idle) begin
            ini_d.done = 1'b1;
        end
    end

    assign pending = (ini_q.pause == PAUSE_END) && (ini_q.left != '0);
    assign done    = ini_q.done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ini_q <= '{pause: '0, left: COUNT_V, done: 1'b0};
        end else begin
            ini_q <= ini_d;
        end
    end
endmodule

// File: rtl/dram_ref_strobe.sv
module dram_ref_strobe #(
    parameter bit          USE_CBR  = 1'b1,
    parameter int unsigned ROW_W    = 12,
    parameter int unsigned LEAD_CYC = 1,
    parameter int unsigned RAS_CYC  = 9,
    parameter int unsigned PRE_CYC  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             addr_drive,
    output logic             idle
);
    import dram_ref_pkg::*;

    localparam int unsigned PCW = cnt_width(max3(LEAD_CYC, RAS_CYC, PRE_CYC));
    localparam logic [PCW-1:0] LEAD_LAST = PCW'(LEAD_CYC - 1);
    localparam logic [PCW-1:0] RAS_LAST  = PCW'(RAS_CYC - 1);
    localparam logic [PCW-1:0] PRE_LAST  = PCW'(PRE_CYC - 1);

    typedef struct packed {
        ref_phase_e       phase;
        logic [PCW-1:0]   cnt;
        logic [ROW_W-1:0] row;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic             drive;
    } seq_t;

    seq_t seq_d, seq_q;
    logic col_first;    // column strobe joins this phase
    logic row_step;     // row-only refresh just finished its active phase

    generate
        if (USE_CBR) begin : g_cbr
            assign col_first = (seq_d.phase == PH_LEAD) || (seq_d.phase == PH_ACT);
            assign row_step  = 1'b0;
        end else begin : g_row_only
            assign col_first = 1'b0;
            assign row_step  = (seq_q.phase == PH_ACT) && (seq_q.cnt == '0);
        end
    endgenerate

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start) begin
                    seq_d.phase = PH_LEAD;
                    seq_d.cnt   = LEAD_LAST;
                end
            end
            PH_LEAD: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_ACT;
                    seq_d.cnt   = RAS_LAST;
                end else begin
                    seq_d.cnt = seq_q.cnt - PCW'(1);
                end
            end
            PH_ACT: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_PRE;
                    seq_d.cnt   = PRE_LAST;
                end else begin
                    seq_d.cnt = seq_q.cnt - PCW'(1);
                end
            end
            PH_PRE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - PCW'(1);
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
        if (row_step) begin
            seq_d.row = seq_q.row + ROW_W'(1);
        end
        seq_d.ras_n = (seq_d.phase != PH_ACT);
        seq_d.cas_n = !col_first;
        seq_d.we_n  = 1'b1;
        seq_d.drive = !USE_CBR && (seq_d.phase != PH_IDLE);
    end

    assign ras_n      = seq_q.ras_n;
    assign cas_n      = seq_q.cas_n;
    assign we_n       = seq_q.we_n;
    assign row_addr   = seq_q.row;
    assign addr_drive = seq_q.drive;
    assign idle       = (seq_q.phase == PH_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, cnt: '0, row: '0, ras_n: 1'b1,
                       cas_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
    parameter bit          USE_CBR        = 1'b1,
    parameter int unsigned ROW_W          = 12,
    parameter int unsigned INIT_PAUSE_CYC = 25000,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned INTERVAL_CYC   = 1950,
    parameter int unsigned LEAD_CYC       = 1,
    parameter int unsigned RAS_CYC        = 9,
    parameter int unsigned PRE_CYC        = 7,
    parameter int unsigned MAX_OWED       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_gnt,
    output logic             ref_req,
    output logic             ras_n,
    output logic             cas_n,
    output logic             we_n,
    output logic [ROW_W-1:0] row_addr,
    output logic             addr_drive,
    output logic             init_done,
    output logic             starve_err
);
    logic seq_idle;
    logic init_pending;
    logic debt_pending;
    logic tick;
    logic start;
    logic any_pending;

    assign any_pending = init_pending || debt_pending;
    assign start       = seq_idle && any_pending && ref_gnt;
    assign ref_req     = !seq_idle || any_pending;

    dram_ref_init #(
        .PAUSE_CYC (INIT_PAUSE_CYC),
        .INIT_COUNT(INIT_REFRESHES)
    ) init_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (start && !init_done),
        .seq_idle(seq_idle),
        .pending (init_pending),
        .done    (init_done)
    );

    dram_ref_interval #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) timer_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (init_done),
        .tick (tick)
    );

    dram_ref_debt #(
        .MAX_OWED(MAX_OWED)
    ) debt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .take   (start && init_done),
        .pending(debt_pending),
        .starve (starve_err)
    );

    dram_ref_strobe #(
        .USE_CBR (USE_CBR),
        .ROW_W   (ROW_W),
        .LEAD_CYC(LEAD_CYC),
        .RAS_CYC (RAS_CYC),
        .PRE_CYC (PRE_CYC)
    ) strobe_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .row_addr  (row_addr),
        .addr_drive(addr_drive),
        .idle      (seq_idle)
    );
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
    parameter bit          USE_CBR = 1'b1,
    parameter int unsigned ROW_W   = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_req,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [ROW_W-1:0] row_addr,
    input logic             init_done,
    input logic             starve_err
);
    assert_we_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> we_n);

    assert_cas_lead_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (USE_CBR && $fell(ras_n)) |-> (!cas_n && $past(!cas_n)));

    assert_cas_rise_with_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (USE_CBR && $rose(ras_n)) |-> cas_n);

    assert_row_only_cas_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!USE_CBR && !ras_n) |-> cas_n);

    assert_row_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n)) |-> $stable(row_addr));

    assert_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |=> ras_n);

    assert_idle_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_req |-> (ras_n && cas_n));

    assert_init_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_done) |-> init_done);

    assert_starve_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(starve_err) |-> starve_err);
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
    .USE_CBR(USE_CBR),
    .ROW_W  (ROW_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_req   (ref_req),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .row_addr  (row_addr),
    .init_done (init_done),
    .starve_err(starve_err)
);

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb_top;
    localparam int P_PAUSE = 50;
    localparam int P_INIT  = 8;
    localparam int P_IVL   = 40;
    localparam int P_IVL_R = 16;
    localparam int P_LEAD  = 2;
    localparam int P_RAS   = 5;
    localparam int P_PRE   = 4;
    localparam int P_MAX   = 3;
    localparam int P_ROWW  = 12;
    localparam int PERIOD  = P_LEAD + P_RAS + P_PRE + 1;
    localparam int ROWS    = 1 << P_ROWW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b1;

    logic req, ras_n, cas_n, we_n, drv, done, starve;
    logic [P_ROWW-1:0] row;
    logic ro_req, ro_ras_n, ro_cas_n, ro_we_n, ro_drv, ro_done, ro_starve;
    logic [P_ROWW-1:0] ro_row;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_seq #(
        .USE_CBR(1'b1), .ROW_W(P_ROWW), .INIT_PAUSE_CYC(P_PAUSE),
        .INIT_REFRESHES(P_INIT), .INTERVAL_CYC(P_IVL), .LEAD_CYC(P_LEAD),
        .RAS_CYC(P_RAS), .PRE_CYC(P_PRE), .MAX_OWED(P_MAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_gnt(gnt), .ref_req(req), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .row_addr(row), .addr_drive(drv),
        .init_done(done), .starve_err(starve)
    );

    dram_refresh_seq #(
        .USE_CBR(1'b0), .ROW_W(P_ROWW), .INIT_PAUSE_CYC(P_PAUSE),
        .INIT_REFRESHES(P_INIT), .INTERVAL_CYC(P_IVL_R), .LEAD_CYC(P_LEAD),
        .RAS_CYC(P_RAS), .PRE_CYC(P_PRE), .MAX_OWED(P_MAX)
    ) dut_ro_i (
        .clk(clk), .rst_n(rst_n), .ref_gnt(1'b1), .ref_req(ro_req), .ras_n(ro_ras_n),
        .cas_n(ro_cas_n), .we_n(ro_we_n), .row_addr(ro_row), .addr_drive(ro_drv),
        .init_done(ro_done), .starve_err(ro_starve)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // strobe monitor for the column-before-row instance
    int fall_cnt = 0;
    int last_fall = 0;
    int lead_run = 0;
    int low_run = 0;
    int ras_hi_run = 0;
    bit p_cas = 1, p_ras = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_cas && !cas_n) begin
                fall_cnt++;
                if (fall_cnt >= 2 && fall_cnt <= P_INIT)
                    chk(cyc - last_fall == PERIOD, "R3 init spacing", cyc - last_fall, PERIOD);
                chk(ras_hi_run >= P_PRE, "R7 precharge before fall", ras_hi_run, P_PRE);
                last_fall = cyc;
                lead_run = 1;
            end else if (!cas_n && ras_n) begin
                lead_run++;
            end
            if (p_ras && !ras_n) begin
                chk(lead_run == P_LEAD, "R4 column lead", lead_run, P_LEAD);
                chk(we_n == 1'b1, "R5 we at row fall", we_n, 1);
                low_run = 1;
            end else if (!ras_n) begin
                if (!p_ras) low_run++;
            end
            if (!p_ras && ras_n) begin
                chk(low_run == P_RAS, "R4 row low width", low_run, P_RAS);
                chk(cas_n == 1'b1, "R4 column rises with row", cas_n, 1);
            end
            if (!req)
                chk(ras_n && cas_n, "R8 idle strobes", {ras_n, cas_n}, 3);
            ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
            p_cas = cas_n;
            p_ras = ras_n;
        end
    end

    // row monitor for the row-only instance
    int ro_falls = 0;
    int ro_exp = 0;
    int ro_wraps = 0;
    bit p_ro_ras = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ro_ras && !ro_ras_n) begin
                ro_falls++;
                chk(int'(ro_row) == ro_exp, "R6 row sequence", ro_row, ro_exp);
                chk(ro_cas_n == 1'b1, "R6 column high", ro_cas_n, 1);
                ro_exp = (ro_exp + 1) % ROWS;
                if (ro_exp == 0) ro_wraps++;
            end
            p_ro_ras = ro_ras_n;
        end
    end

    task automatic wait_falls(input int target);
        while (fall_cnt < target) step();
    endtask

    initial begin
        int d;
        int f0;
        step();
        step();
        chk(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
        chk(!req && !done && !starve, "R1 flags in reset", {req, done, starve}, 0);
        chk(ro_ras_n && ro_cas_n && !ro_req, "R1 row-only reset", {ro_ras_n, ro_cas_n, ro_req}, 6);
        rst_n = 1'b1;
        for (int k = 1; k <= P_PAUSE; k++) begin
            step();
            if (k < P_PAUSE) begin
                if (req) chk(1'b0, "R2 request during pause", k, P_PAUSE);
            end else begin
                chk(req == 1'b1, "R2 request after pause", req, 1);
            end
        end
        n_chk++;
        while (!done) step();
        d = cyc;
        chk(fall_cnt == P_INIT, "R3 init refresh count", fall_cnt, P_INIT);
        wait_falls(P_INIT + 1);
        chk(last_fall - d == P_IVL + 1, "R9 first timed refresh", last_fall - d, P_IVL + 1);
        f0 = last_fall;
        wait_falls(P_INIT + 2);
        chk(last_fall - f0 == P_IVL, "R9 interval", last_fall - f0, P_IVL);
        f0 = last_fall;
        wait_falls(P_INIT + 3);
        chk(last_fall - f0 == P_IVL, "R9 interval again", last_fall - f0, P_IVL);
        // withhold the grant
        gnt = 1'b0;
        repeat (4 * P_IVL - 2) step();
        chk(starve == 1'b0, "R10 no error before overflow", starve, 0);
        chk(req == 1'b1, "R8 request held while refused", req, 1);
        chk(fall_cnt == P_INIT + 3, "R8 no strobe without grant", fall_cnt, P_INIT + 3);
        step();
        chk(starve == 1'b1, "R10 error on overflow", starve, 1);
        gnt = 1'b1;
        f0 = fall_cnt;
        repeat (38) step();
        chk(fall_cnt - f0 == P_MAX, "R10 debt drained", fall_cnt - f0, P_MAX);
        chk(req == 1'b0, "R10 request drops after drain", req, 0);
        chk(starve == 1'b1, "R11 error sticky", starve, 1);
        while (ro_falls < ROWS + 4) step();
        chk(ro_wraps >= 1, "R6 row wrap seen", ro_wraps, 1);
        chk(starve == 1'b1, "R11 error still set", starve, 1);
        rst_n = 1'b0;
        step();
        chk(!starve && !done && !req, "R11 reset clears", {starve, done, req}, 0);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wait (cyc >= 190000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule